// File: doc/BRIEF.md
# Linked-List XOR Parity Engine

This block builds RAID parity by XOR-ing between one and sixteen source buffers, one word at a time, into a single target buffer. Software describes the work as a chain of command blocks in memory and gives the engine the address of the first one with a start pulse. For each block the engine reads the block, reads the sources, writes the XOR result to the target, writes a status word back to memory, and then follows the block's link to the next block.

All memory traffic goes through one request port. A request is held until it is granted. Write data is accepted on the grant. A read returns its data, together with an error flag, on a later response strobe. Only one read is in flight at a time. A zero link ends the chain, and the end of the chain is signalled by a one-cycle interrupt pulse.

Top module: `xor_parity_engine`

## Requirements
- R1: After reset, busy, mem_req and irq_done are low.
- R2: A command block at address A is laid out as follows. Word A holds the control field: bits [3:0] are the source count minus one, and bits [31:16] are the length in words. Word A+1 is the link, A+2 the target address, A+3 the status address, and A+4 onward hold the source addresses. The engine reads these words in ascending address order, and only as many source words as the count gives.
- R3: For each word index w, from 0 upward, the engine reads source s at address src_s+w for s from 0 to count-1. It then writes the XOR of those values to target+w. Sources and target may be at any address.
- R4: A command block with sixteen sources produces the XOR of all sixteen.
- R5: After the last target write of a command block, the engine writes the value 0x00000001 to that block's status address.
- R6: A read error on a source stops all further source reads and target writes for that block. The engine writes status 0x2 | (s<<4) | (w<<16) to the status address, with s the source index and w the word index of the failing read, and then continues with the link.
- R7: After the status write of a block whose link is zero, irq_done pulses for one cycle with irq_err low, and busy is low.
- R8: A read error while fetching a command block stops the chain. No further requests are made, and irq_done pulses with irq_err high.
- R9: A block with length zero makes no source reads and no target writes, and it writes status 0x00000001.
- R10: A start with a zero head address makes no memory request and gives an irq_done pulse with irq_err low.
- R11: A start pulse while busy is ignored. The running chain's request stream is unchanged.
- R12: While mem_req is high and not granted, mem_req, mem_we, mem_addr and mem_wdata stay stable.
- R13: While a read is granted and its response has not yet arrived, no new request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; sampled only when idle |
| head_addr | input | AW | Address of the first command block |
| busy | output | 1 | High while a chain is being processed |
| irq_done | output | 1 | One-cycle pulse when the chain ends |
| irq_err | output | 1 | High with irq_done when a command block fetch failed |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read response strobe, at least one cycle after the grant |
| mem_rdata | input | DW | Read data |
| mem_rerr | input | 1 | Read response carries an error |

## Verification
The hardest case to reach is an error on one particular source, deep inside a multi-source block, followed by a chain that must carry on. Reaching it needs the failing read to land on an exact source index and word index. The bench places the sources of one block at stride-16 addresses, so each read address maps to a single (source, word) pair. It then marks exactly one of those addresses as an erroring location in its memory model. Grants are stalled at random and read latency varies, so the request-hold and single-outstanding-read rules are exercised at every state. A second start pulse is injected in the middle of a chain.

// File: rtl/xpe_pkg.sv
package xpe_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DREQ,
        S_DWAIT,
        S_SREQ,
        S_SWAIT,
        S_TWR,
        S_STAT
    } xpe_state_e;

    // command block word offsets (the fetch sequence depends on them)
    localparam int OFF_CTRL = 0;
    localparam int OFF_LINK = 1;
    localparam int OFF_TGT  = 2;
    localparam int OFF_STAT = 3;
    localparam int HDR_WORDS = 4;

    // control field positions
    localparam int CNT_LSB = 0;
    localparam int LEN_LSB = 16;

    // status encoding
    localparam int STAT_OK       = 1;
    localparam int STAT_ERR      = 2;
    localparam int ERR_SRC_LSB   = 4;
    localparam int ERR_WORD_LSB  = 16;

endpackage

// File: rtl/xpe_src_table.sv
module xpe_src_table #(
    parameter int AW    = 32,
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [AW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [AW-1:0] rdata
);

    logic [AW-1:0] ent_d [DEPTH];
    logic [AW-1:0] ent_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_d[i] = ent_q[i];
            if (we && (widx == IW'(i))) begin
                ent_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                ent_q[i] <= '0;
            end else begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    assign rdata = ent_q[ridx];

endmodule

// File: rtl/xpe_xor_acc.sv
module xpe_xor_acc #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          fold,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] acc
);

    logic [DW-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (load) begin
            acc_d = din;
        end else if (fold) begin
            acc_d = acc_q ^ din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc = acc_q;

endmodule

// File: rtl/xpe_ctrl.sv
module xpe_ctrl
    import xpe_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int MAX_SRC = 16,
    parameter int LEN_W   = 16,
    localparam int SW     = $clog2(MAX_SRC),
    localparam int FW     = $clog2(HDR_WORDS + MAX_SRC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] head_addr,
    output logic          busy,
    output logic          irq_done,
    output logic          irq_err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_rerr,
    output logic          tbl_we,
    output logic [SW-1:0] tbl_widx,
    output logic [SW-1:0] tbl_ridx,
    input  logic [AW-1:0] tbl_raddr,
    output logic          acc_load,
    output logic          acc_fold,
    input  logic [DW-1:0] acc_val
);

    typedef struct packed {
        xpe_state_e       st;
        logic [AW-1:0]    cur;
        logic [FW-1:0]    fidx;
        logic [SW-1:0]    nm1;
        logic [LEN_W-1:0] len;
        logic [AW-1:0]    link;
        logic [AW-1:0]    tgt;
        logic [AW-1:0]    sta;
        logic [LEN_W-1:0] widx;
        logic [SW-1:0]    sidx;
        logic [DW-1:0]    status;
        logic             irq;
        logic             ierr;
    } ctl_t;

    ctl_t r_d, r_q;

    logic last_desc_word;
    assign last_desc_word = (r_q.fidx == (FW'(HDR_WORDS) + FW'(r_q.nm1)));

    always_comb begin
        r_d       = r_q;
        r_d.irq   = 1'b0;
        r_d.ierr  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        tbl_we    = 1'b0;
        acc_load  = 1'b0;
        acc_fold  = 1'b0;

        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    if (head_addr == '0) begin
                        r_d.irq = 1'b1;
                    end else begin
                        r_d.cur  = head_addr;
                        r_d.fidx = '0;
                        r_d.st   = S_DREQ;
                    end
                end
            end

            S_DREQ: begin
                mem_req  = 1'b1;
                mem_addr = r_q.cur + AW'(r_q.fidx);
                if (mem_gnt) r_d.st = S_DWAIT;
            end

            S_DWAIT: begin
                if (mem_rvalid) begin
                    if (mem_rerr) begin
                        r_d.irq  = 1'b1;
                        r_d.ierr = 1'b1;
                        r_d.st   = S_IDLE;
                    end else begin
                        if (r_q.fidx == FW'(OFF_CTRL)) begin
                            r_d.nm1 = mem_rdata[CNT_LSB +: SW];
                            r_d.len = mem_rdata[LEN_LSB +: LEN_W];
                        end else if (r_q.fidx == FW'(OFF_LINK)) begin
                            r_d.link = AW'(mem_rdata);
                        end else if (r_q.fidx == FW'(OFF_TGT)) begin
                            r_d.tgt = AW'(mem_rdata);
                        end else if (r_q.fidx == FW'(OFF_STAT)) begin
                            r_d.sta = AW'(mem_rdata);
                        end else begin
                            tbl_we = 1'b1;
                        end

                        if (r_q.fidx >= FW'(HDR_WORDS) && last_desc_word) begin
                            r_d.widx = '0;
                            r_d.sidx = '0;
                            if (r_q.len == '0) begin
                                r_d.status = DW'(STAT_OK);
                                r_d.st     = S_STAT;
                            end else begin
                                r_d.st = S_SREQ;
                            end
                        end else begin
                            r_d.fidx = r_q.fidx + 1'b1;
                            r_d.st   = S_DREQ;
                        end
                    end
                end
            end

            S_SREQ: begin
                mem_req  = 1'b1;
                mem_addr = tbl_raddr + AW'(r_q.widx);
                if (mem_gnt) r_d.st = S_SWAIT;
            end

            S_SWAIT: begin
                if (mem_rvalid) begin
                    if (mem_rerr) begin
                        r_d.status = DW'(STAT_ERR)
                                   | (DW'(r_q.sidx) << ERR_SRC_LSB)
                                   | (DW'(r_q.widx) << ERR_WORD_LSB);
                        r_d.st = S_STAT;
                    end else begin
                        acc_load = (r_q.sidx == '0);
                        acc_fold = (r_q.sidx != '0);
                        if (r_q.sidx == r_q.nm1) begin
                            r_d.st = S_TWR;
                        end else begin
                            r_d.sidx = r_q.sidx + 1'b1;
                            r_d.st   = S_SREQ;
                        end
                    end
                end
            end

            S_TWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.tgt + AW'(r_q.widx);
                mem_wdata = acc_val;
                if (mem_gnt) begin
                    if (r_q.widx == (r_q.len - 1'b1)) begin
                        r_d.status = DW'(STAT_OK);
                        r_d.st     = S_STAT;
                    end else begin
                        r_d.widx = r_q.widx + 1'b1;
                        r_d.sidx = '0;
                        r_d.st   = S_SREQ;
                    end
                end
            end

            S_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.sta;
                mem_wdata = r_q.status;
                if (mem_gnt) begin
                    if (r_q.link == '0) begin
                        r_d.irq = 1'b1;
                        r_d.st  = S_IDLE;
                    end else begin
                        r_d.cur  = r_q.link;
                        r_d.fidx = '0;
                        r_d.st   = S_DREQ;
                    end
                end
            end

            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != S_IDLE);
    assign irq_done = r_q.irq;
    assign irq_err  = r_q.ierr;
    assign tbl_widx = SW'(r_q.fidx - FW'(HDR_WORDS));
    assign tbl_ridx = r_q.sidx;

endmodule

// File: rtl/xor_parity_engine.sv
module xor_parity_engine #(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int MAX_SRC = 16,
    parameter int LEN_W   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] head_addr,
    output logic          busy,
    output logic          irq_done,
    output logic          irq_err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_rerr
);

    localparam int SW = $clog2(MAX_SRC);

    logic          tbl_we;
    logic [SW-1:0] tbl_widx;
    logic [SW-1:0] tbl_ridx;
    logic [AW-1:0] tbl_raddr;
    logic          acc_load;
    logic          acc_fold;
    logic [DW-1:0] acc_val;

    xpe_ctrl #(
        .AW(AW), .DW(DW), .MAX_SRC(MAX_SRC), .LEN_W(LEN_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .head_addr(head_addr),
        .busy(busy), .irq_done(irq_done), .irq_err(irq_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
        .tbl_we(tbl_we), .tbl_widx(tbl_widx), .tbl_ridx(tbl_ridx),
        .tbl_raddr(tbl_raddr), .acc_load(acc_load), .acc_fold(acc_fold),
        .acc_val(acc_val)
    );

    xpe_src_table #(
        .AW(AW), .DEPTH(MAX_SRC)
    ) u_tbl (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(tbl_widx),
        .wdata(AW'(mem_rdata)), .ridx(tbl_ridx), .rdata(tbl_raddr)
    );

    xpe_xor_acc #(
        .DW(DW)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .load(acc_load), .fold(acc_fold),
        .din(mem_rdata), .acc(acc_val)
    );

endmodule

// File: rtl/xpe_checker.sv
module xpe_checker #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          irq_done,
    input logic          irq_err,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_gnt,
    input logic          mem_rvalid
);

    logic rd_out_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_out_q <= 1'b0;
        end else if (mem_req && mem_gnt && !mem_we) begin
            rd_out_q <= 1'b1;
        end else if (mem_rvalid) begin
            rd_out_q <= 1'b0;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata))); // R12

    AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_out_q |-> !mem_req); // R13

    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> !busy); // R7

    AST_ERR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> irq_done); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R10

endmodule

bind xor_parity_engine xpe_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .irq_done(irq_done),
    .irq_err(irq_err), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid)
);

// File: tb/xor_parity_engine_test.sv
module xor_parity_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] head_addr = '0;
    logic        busy, irq_done, irq_err;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_rerr = 1'b0;

    always #4 clk = ~clk;

    xor_parity_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .head_addr(head_addr),
        .busy(busy), .irq_done(irq_done), .irq_err(irq_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_rerr(mem_rerr)
    );

    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [31:0] data;
    } req_t;

    logic [31:0] mem  [0:1023];
    logic [31:0] rmem [0:1023];
    req_t        expq [$];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    string       cur_tag = "R1";
    int          checks = 0;
    int          fails = 0;
    int          irq_cnt = 0;
    bit          last_err = 0;
    bit          done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference of the request stream
    task automatic mrd(input logic [31:0] a, output logic [31:0] d, output bit e);
        expq.push_back('{1'b0, a, 32'h0});
        e = (a == err_addr);
        d = rmem[a[9:0]];
    endtask

    task automatic mwr(input logic [31:0] a, input logic [31:0] d);
        expq.push_back('{1'b1, a, d});
        rmem[a[9:0]] = d;
    endtask

    task automatic run_model(input logic [31:0] head, output bit cerr);
        logic [31:0] cur, c, lnk, tg, st, d, acc, status;
        logic [31:0] src [16];
        bit e;
        int n, len;
        cerr = 0;
        cur = head;
        while (cur != 0) begin
            mrd(cur, c, e);     if (e) begin cerr = 1; return; end
            n = int'(c[3:0]) + 1;
            len = int'(c[31:16]);
            mrd(cur + 1, lnk, e); if (e) begin cerr = 1; return; end
            mrd(cur + 2, tg, e);  if (e) begin cerr = 1; return; end
            mrd(cur + 3, st, e);  if (e) begin cerr = 1; return; end
            for (int i = 0; i < n; i++) begin
                mrd(cur + 4 + i, src[i], e);
                if (e) begin cerr = 1; return; end
            end
            status = 32'h1;
            for (int w = 0; w < len && status == 32'h1; w++) begin
                acc = 0;
                for (int s = 0; s < n; s++) begin
                    mrd(src[s] + w, d, e);
                    if (e) begin
                        status = 32'h2 | (s << 4) | (w << 16);
                        break;
                    end
                    acc ^= d;
                end
                if (status == 32'h1) mwr(tg + w, acc);
            end
            mwr(st, status);
            cur = lnk;
        end
    endtask

    // ---------------- memory agent, compared on every clock
    initial begin : agent
        bit          pend = 0;
        int          cnt = 0;
        logic [31:0] pdata = '0;
        bit          perr = 0;
        bit          g;
        req_t        e;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            mem_rerr   = 1'b0;
            if (irq_done) begin
                irq_cnt++;
                last_err = irq_err;
            end
            if (pend) begin
                if (cnt == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = pdata;
                    mem_rerr   = perr;
                    pend = 0;
                end else begin
                    cnt--;
                end
            end
            g = rst_n && (($urandom % 4) != 0);
            if (mem_req && g) begin
                if (expq.size() == 0) begin
                    chk(0, cur_tag, "unexpected request addr", mem_addr, 32'h0);
                end else begin
                    e = expq.pop_front();
                    chk(mem_we == e.we, cur_tag, "request direction", 32'(mem_we), 32'(e.we));
                    chk(mem_addr == e.addr, cur_tag, "request address", mem_addr, e.addr);
                    if (e.we) chk(mem_wdata == e.data, cur_tag, "write data", mem_wdata, e.data);
                end
                if (mem_we) begin
                    mem[mem_addr[9:0]] = mem_wdata;
                end else begin
                    pend  = 1;
                    cnt   = int'($urandom % 3);
                    pdata = mem[mem_addr[9:0]];
                    perr  = (mem_addr == err_addr);
                end
            end
            mem_gnt = g;
        end
    end

    // ---------------- helpers
    task automatic mkdesc(input int a, input int n, input int len, input int lnk,
                          input int tg, input int st, input int sbase, input int stride);
        mem[a]     = (len << 16) | (n - 1);
        mem[a + 1] = lnk;
        mem[a + 2] = tg;
        mem[a + 3] = st;
        for (int i = 0; i < n; i++) mem[a + 4 + i] = sbase + i * stride;
    endtask

    task automatic run(input logic [31:0] head, input string tag, input bit poke);
        bit cerr;
        int t;
        int bad;
        for (int i = 0; i < 1024; i++) rmem[i] = mem[i];
        expq.delete();
        run_model(head, cerr);
        cur_tag = tag;
        irq_cnt = 0;
        @(negedge clk);
        start = 1'b1;
        head_addr = head;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (6) @(negedge clk);
            // R11: second start while busy must be ignored
            start = 1'b1;
            head_addr = 32'h10;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (irq_cnt == 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 20000, tag, "watchdog expired waiting for irq", t, 20000);
        repeat (3) @(negedge clk);
        chk(irq_cnt == 1, tag, "irq pulse count", irq_cnt, 1);
        chk(last_err == cerr, tag, "irq_err", 32'(last_err), 32'(cerr));
        chk(busy == 1'b0, tag, "busy after chain", 32'(busy), 0);
        chk(expq.size() == 0, tag, "requests still expected", expq.size(), 0);
        bad = -1;
        for (int i = 0; i < 1024; i++) if (bad < 0 && mem[i] !== rmem[i]) bad = i;
        if (bad < 0) chk(1, tag, "memory image", 0, 0);
        else chk(0, tag, "memory image word", mem[bad], rmem[bad]);
        err_addr = 32'hFFFF_FFFF;
    endtask

    // ---------------- global watchdog
    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- test sequence
    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = $urandom;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(busy == 0, "R1", "busy in reset", 32'(busy), 0);
        chk(mem_req == 0, "R1", "mem_req in reset", 32'(mem_req), 0);
        chk(irq_done == 0, "R1", "irq_done in reset", 32'(irq_done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 0 && mem_req == 0, "R1", "idle after reset", 32'(busy), 0);

        // R2 R3 R5 R7: single source copy
        mkdesc(32'h10, 1, 4, 0, 32'h300, 32'h3F0, 32'h100, 1);
        run(32'h10, "R3", 0);
        chk(mem[32'h3F0] == 32'h1, "R5", "status word", mem[32'h3F0], 32'h1);

        // R4: sixteen sources
        mkdesc(32'h20, 16, 3, 0, 32'h310, 32'h3F1, 32'h100, 8);
        run(32'h20, "R4", 0);

        // R2 R7 R11: three-block chain with a start pulse while busy
        mkdesc(32'h40, 3, 5, 32'h60, 32'h320, 32'h3F2, 32'h200, 7);
        mkdesc(32'h60, 2, 2, 32'h80, 32'h330, 32'h3F3, 32'h240, 3);
        mkdesc(32'h80, 5, 1, 0,      32'h340, 32'h3F4, 32'h260, 2);
        run(32'h40, "R11", 1);
        chk(mem[32'h3F4] == 32'h1, "R7", "last status in chain", mem[32'h3F4], 32'h1);

        // R6: source error on source 2, word 3, then chain continues
        mkdesc(32'h90, 4, 6, 32'hB0, 32'h350, 32'h3F5, 32'h180, 16);
        mkdesc(32'hB0, 2, 2, 0,      32'h360, 32'h3F6, 32'h1C0, 4);
        err_addr = 32'h1A3;
        run(32'h90, "R6", 0);
        chk(mem[32'h3F5] == 32'h0003_0022, "R6", "error status", mem[32'h3F5], 32'h0003_0022);
        chk(mem[32'h3F6] == 32'h1, "R6", "next block after error", mem[32'h3F6], 32'h1);

        // R8: descriptor fetch error on second block
        mkdesc(32'hC0, 2, 2, 32'hD0, 32'h370, 32'h3F7, 32'h1D0, 2);
        mkdesc(32'hD0, 2, 2, 0,      32'h380, 32'h3F8, 32'h1E0, 2);
        err_addr = 32'hD2;
        run(32'hC0, "R8", 0);
        chk(last_err == 1'b1, "R8", "irq_err on fetch error", 32'(last_err), 1);

        // R9: zero length
        mkdesc(32'hE0, 3, 0, 0, 32'h390, 32'h3F9, 32'h100, 1);
        run(32'hE0, "R9", 0);
        chk(mem[32'h3F9] == 32'h1, "R9", "status with zero length", mem[32'h3F9], 32'h1);

        // R10: null head
        run(32'h0, "R10", 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule